// File: doc/BRIEF.md
# DMA Request/Grant Handshake Controller

This block is the per-channel handshake engine for a DMA channel that serves an external device with no bus-mastering ability. The device pulls an active-low request pin to start a transfer. The controller synchronises that pin into its own clock domain and then asks a bus arbiter for the external bus. Once the arbiter reports that the bus is owned, the controller answers in one of three ways, picked by a mode field.

In plain handshake mode the controller drives an active-low grant and holds it until the device releases its request. In external-handshake mode it also runs one memory access cycle per request. During that cycle it drives a memory select and a read or write strobe, and it keeps the cycle open for the programmed wait states and for as long as acknowledge is held low. The grant then stays low until the request is released. In paced-master mode the controller never drives the grant. It answers the request with the select and strobe alone, and it keeps the strobe active while the request is still held low. The mode and the direction are captured when a request is accepted. Address generation and data storage belong to neighbouring blocks.

Top module: `dreq_hs_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, dev_gnt_n, mem_sel_n, rd_n and wr_n are high and bus_req is low.
- R2: dev_req_n passes through a two-flop synchroniser. A low level that is present at two consecutive rising edges raises bus_req one cycle later. The grant and the access cycle begin only in the cycle after bus_own is sampled high while arbitrating. As long as bus_own stays low, dev_gnt_n stays high and bus_req stays high. With bus_own already high, dev_gnt_n is first seen low at the fourth falling edge after dev_req_n falls.
- R3: In handshake mode (mode_cfg = 2'b00), dev_gnt_n stays low while the synchronised request is held. In the third cycle after dev_req_n returns high, dev_gnt_n is high and bus_req is low.
- R4: In external-handshake mode (mode_cfg = 2'b01), mem_sel_n, dev_gnt_n and one strobe go low together. The strobe is rd_n when dir_cfg = 0 and wr_n when dir_cfg = 1. The strobe lasts wait_cfg + 1 cycles, plus one cycle for each cycle in which mem_ack is low once the wait count has run out. Exactly one access is made per request.
- R5: In external-handshake mode, dev_gnt_n stays low after the strobe ends, until the request is released. It then behaves as in R3.
- R6: In paced-master mode (mode_cfg = 2'b10), dev_gnt_n is never low. The select and the strobe stay low until all three of these hold: the wait count has run out, mem_ack is high, and the synchronised request is low. The next cycle they go high and bus_req drops.
- R7: When chan_en is low, or when dev_req_n stays high, bus_req, the grant and the strobes stay inactive.
- R8: mode_cfg = 2'b11 is reserved. A request in that mode is ignored and leaves all outputs inactive.
- R9: mode_cfg and dir_cfg are captured when a request is accepted. Changing them during a transfer does not alter that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| chan_en | input | 1 | Channel enable; checked when a request is accepted |
| mode_cfg | input | 2 | 00 handshake, 01 external handshake, 10 paced master, 11 reserved |
| dir_cfg | input | 1 | 0 read strobe, 1 write strobe |
| wait_cfg | input | WAIT_W (3) | Wait states added to each access |
| dev_req_n | input | 1 | Active-low request from the device (asynchronous) |
| dev_gnt_n | output | 1 | Active-low grant to the device |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_own | input | 1 | Arbiter reports that the external bus is owned |
| mem_ack | input | 1 | Memory acknowledge; low stretches the access |
| mem_sel_n | output | 1 | Active-low memory select during an access |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
The assertions assume that bus_own is a level the arbiter holds while it owns the bus. They also assume that chan_en changes only while the block is idle and that reset is released away from the rising edge. The stimulus changes every input only at falling edges. It raises bus_own before or during arbitration and never drops it mid-transfer, and it changes mode_cfg or dir_cfg during a transfer only in the test for R9. Every request is held low across at least one rising edge, so the synchroniser always catches it.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  typedef enum logic [1:0] {
    MODE_HS   = 2'b00,
    MODE_XHS  = 2'b01,
    MODE_PACE = 2'b10,
    MODE_RSVD = 2'b11
  } hs_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARB    = 2'd1,
    ST_ACCESS = 2'd2,
    ST_GRANT  = 2'd3
  } hs_state_e;
endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[0] <= 1'b0;
          else        pipe_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[i] <= 1'b0;
          else        pipe_q[i] <= pipe_q[i-1];
        end
      end
    end
  endgenerate

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/dreq_wait_cnt.sv
module dreq_wait_cnt #(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              dec,
  input  logic [WAIT_W-1:0] load_val,
  output logic              zero
);
  localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);

  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  assign cnt_en = load | dec;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/dreq_fsm.sv
module dreq_fsm
  import dreq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_en,
  input  logic [1:0] mode_cfg,
  input  logic       dir_cfg,
  input  logic       req_s,
  input  logic       bus_own,
  input  logic       mem_ack,
  input  logic       cnt_zero,
  output logic       cnt_load,
  output logic       cnt_dec,
  output logic       gnt_act,
  output logic       breq_act,
  output logic       sel_act,
  output logic       rd_act,
  output logic       wr_act
);
  hs_state_e state_q, state_d;
  hs_mode_e  mode_q;
  logic      dir_q;
  logic      accept;
  logic      acc_done;

  assign accept   = (state_q == ST_IDLE) && chan_en && req_s &&
                    (hs_mode_e'(mode_cfg) != MODE_RSVD);
  assign acc_done = cnt_zero && mem_ack;

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_ARB;
      ST_ARB: begin
        if (bus_own) begin
          if (mode_q == MODE_HS) begin
            state_d = ST_GRANT;
          end else begin
            state_d  = ST_ACCESS;
            cnt_load = 1'b1;
          end
        end
      end
      ST_ACCESS: begin
        if (acc_done) begin
          if (mode_q == MODE_XHS) state_d = ST_GRANT;
          else if (!req_s)        state_d = ST_IDLE;
        end
      end
      ST_GRANT:  if (!req_s) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign cnt_dec = (state_q == ST_ACCESS) && !cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_HS;
      dir_q  <= 1'b0;
    end else if (accept) begin
      mode_q <= hs_mode_e'(mode_cfg);
      dir_q  <= dir_cfg;
    end
  end

  assign breq_act = (state_q != ST_IDLE);
  assign sel_act  = (state_q == ST_ACCESS);
  assign rd_act   = sel_act && !dir_q;
  assign wr_act   = sel_act && dir_q;
  assign gnt_act  = (state_q == ST_GRANT) ||
                    (sel_act && (mode_q == MODE_XHS));
endmodule

// File: rtl/dreq_hs_ctrl.sv
module dreq_hs_ctrl #(
  parameter int WAIT_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic [1:0]        mode_cfg,
  input  logic              dir_cfg,
  input  logic [WAIT_W-1:0] wait_cfg,
  input  logic              dev_req_n,
  output logic              dev_gnt_n,
  output logic              bus_req,
  input  logic              bus_own,
  input  logic              mem_ack,
  output logic              mem_sel_n,
  output logic              rd_n,
  output logic              wr_n
);
  logic req_s;
  logic cnt_load, cnt_dec, cnt_zero;
  logic gnt_act, breq_act, sel_act, rd_act, wr_act;

  dreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (~dev_req_n),
    .dout (req_s)
  );

  dreq_wait_cnt #(.WAIT_W(WAIT_W)) u_wait (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cnt_load),
    .dec     (cnt_dec),
    .load_val(wait_cfg),
    .zero    (cnt_zero)
  );

  dreq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .chan_en (chan_en),
    .mode_cfg(mode_cfg),
    .dir_cfg (dir_cfg),
    .req_s   (req_s),
    .bus_own (bus_own),
    .mem_ack (mem_ack),
    .cnt_zero(cnt_zero),
    .cnt_load(cnt_load),
    .cnt_dec (cnt_dec),
    .gnt_act (gnt_act),
    .breq_act(breq_act),
    .sel_act (sel_act),
    .rd_act  (rd_act),
    .wr_act  (wr_act)
  );

  assign dev_gnt_n = ~gnt_act;
  assign bus_req   = breq_act;
  assign mem_sel_n = ~sel_act;
  assign rd_n      = ~rd_act;
  assign wr_n      = ~wr_act;
endmodule

// File: rtl/dreq_hs_ctrl_chk.sv
module dreq_hs_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic chan_en,
  input logic bus_own,
  input logic dev_gnt_n,
  input logic bus_req,
  input logic mem_sel_n,
  input logic rd_n,
  input logic wr_n
);
  // R2: grant only while the bus is being requested
  a_r2_grant_with_busreq: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_gnt_n |-> bus_req);

  // R2: grant starts only after ownership was seen
  a_r2_grant_after_own: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_gnt_n) |-> $past(bus_own));

  // R4: never both strobes at once
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R4: a strobe always comes with the memory select
  a_r4_strobe_has_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> !mem_sel_n);

  // R7: an idle disabled channel stays idle
  a_r7_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_en && !bus_req) |=> !bus_req);
endmodule

bind dreq_hs_ctrl dreq_hs_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .chan_en  (chan_en),
  .bus_own  (bus_own),
  .dev_gnt_n(dev_gnt_n),
  .bus_req  (bus_req),
  .mem_sel_n(mem_sel_n),
  .rd_n     (rd_n),
  .wr_n     (wr_n)
);

// File: tb/dreq_hs_ctrl_tb_top.sv
`timescale 1ns/1ps
module dreq_hs_ctrl_tb_top;
  logic       clk;
  logic       rst_n;
  logic       chan_en;
  logic [1:0] mode_cfg;
  logic       dir_cfg;
  logic [2:0] wait_cfg;
  logic       dev_req_n;
  logic       dev_gnt_n;
  logic       bus_req;
  logic       bus_own;
  logic       mem_ack;
  logic       mem_sel_n;
  logic       rd_n;
  logic       wr_n;

  int n_checks = 0;
  int n_errors = 0;
  bit done_flag = 0;

  dreq_hs_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .mode_cfg(mode_cfg),
    .dir_cfg(dir_cfg), .wait_cfg(wait_cfg), .dev_req_n(dev_req_n),
    .dev_gnt_n(dev_gnt_n), .bus_req(bus_req), .bus_own(bus_own),
    .mem_ack(mem_ack), .mem_sel_n(mem_sel_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Behavioural reference: phase 0 idle, 1 waiting for bus, 2 access, 3 holding
  int m_ph, m_mode, m_dir, m_wait, m_s1, m_s2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_mode = 0; m_dir = 0; m_wait = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      int seen;
      seen = m_s2;
      if (m_ph == 0) begin
        if (chan_en && seen == 1 && mode_cfg != 2'b11) begin
          m_ph = 1; m_mode = int'(mode_cfg); m_dir = int'(dir_cfg);
        end
      end else if (m_ph == 1) begin
        if (bus_own) begin
          if (m_mode == 0) m_ph = 3;
          else begin m_ph = 2; m_wait = int'(wait_cfg); end
        end
      end else if (m_ph == 2) begin
        if (m_wait == 0 && mem_ack) begin
          if (m_mode == 1) m_ph = 3;
          else if (seen == 0) m_ph = 0;
        end else if (m_wait > 0) m_wait = m_wait - 1;
      end else begin
        if (seen == 0) m_ph = 0;
      end
      m_s2 = m_s1;
      m_s1 = dev_req_n ? 0 : 1;
    end
  end

  // Per-cycle comparison and activity counters
  int c_breq, c_gnt, c_rd, c_wr;
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      logic e_gnt, e_breq, e_sel, e_rd, e_wr;
      e_gnt  = (m_ph == 3) || (m_ph == 2 && m_mode == 1);
      e_breq = (m_ph != 0);
      e_sel  = (m_ph == 2);
      e_rd   = e_sel && (m_dir == 0);
      e_wr   = e_sel && (m_dir == 1);
      n_checks++;
      if ((!dev_gnt_n) !== e_gnt) begin
        n_errors++;
        $display("FAIL R3 model grant act=%0b exp=%0b at %0t", !dev_gnt_n, e_gnt, $time);
      end else if (bus_req !== e_breq) begin
        n_errors++;
        $display("FAIL R2 model bus_req act=%0b exp=%0b at %0t", bus_req, e_breq, $time);
      end else if ({!mem_sel_n, !rd_n, !wr_n} !== {e_sel, e_rd, e_wr}) begin
        n_errors++;
        $display("FAIL R4 model sel/rd/wr act=%b exp=%b at %0t",
                 {!mem_sel_n, !rd_n, !wr_n}, {e_sel, e_rd, e_wr}, $time);
      end
      if (bus_req)    c_breq++;
      if (!dev_gnt_n) c_gnt++;
      if (!rd_n)      c_rd++;
      if (!wr_n)      c_wr++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic clr();
    c_breq = 0; c_gnt = 0; c_rd = 0; c_wr = 0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int k;
    rst_n = 0; chan_en = 1; mode_cfg = 2'b00; dir_cfg = 0; wait_cfg = 0;
    dev_req_n = 1; bus_own = 1; mem_ack = 1;
    clr();
    #1;
    check("R1 grant in reset", dev_gnt_n, 1);
    check("R1 bus_req in reset", bus_req, 0);
    check("R1 strobes in reset", {mem_sel_n, rd_n, wr_n}, 3'b111);
    step(4);
    rst_n = 1;
    step(1);
    check("R1 grant after reset", dev_gnt_n, 1);
    check("R1 bus_req after reset", bus_req, 0);
    step(3);

    // R2/R3 handshake, bus already owned
    dev_req_n = 0;
    k = 0;
    while (dev_gnt_n && k < 20) begin step(1); k++; end
    check("R2 grant latency", k, 4);
    step(10);
    check("R3 grant held", dev_gnt_n, 0);
    dev_req_n = 1;
    step(2);
    check("R3 grant still low 2 cycles after release", dev_gnt_n, 0);
    step(1);
    check("R3 grant released", dev_gnt_n, 1);
    check("R3 bus_req dropped", bus_req, 0);
    step(3);

    // R2 arbitration stall
    bus_own = 0;
    dev_req_n = 0;
    step(10);
    check("R2 no grant without bus", dev_gnt_n, 1);
    check("R2 bus_req while waiting", bus_req, 1);
    bus_own = 1;
    step(1);
    check("R2 grant after ownership", dev_gnt_n, 0);
    dev_req_n = 1;
    step(5);

    // R4/R5 external handshake write, wait 3
    mode_cfg = 2'b01; dir_cfg = 1; wait_cfg = 3; clr();
    dev_req_n = 0;
    step(20);
    check("R4 write strobe width", c_wr, 4);
    check("R4 no read strobe", c_rd, 0);
    check("R5 grant held after access", dev_gnt_n, 0);
    dev_req_n = 1;
    step(5);
    check("R5 grant released", dev_gnt_n, 1);

    // R4 acknowledge stretch, read, wait 0
    dir_cfg = 0; wait_cfg = 0; mem_ack = 0; clr();
    dev_req_n = 0;
    k = 0;
    while (mem_sel_n && k < 20) begin step(1); k++; end
    step(2);
    mem_ack = 1;
    step(5);
    check("R4 read strobe stretched by ack", c_rd, 3);
    check("R4 one access per request", c_wr, 0);
    dev_req_n = 1;
    step(5);

    // R6 paced master, strobe held by request
    mode_cfg = 2'b10; dir_cfg = 0; wait_cfg = 2; clr();
    dev_req_n = 0;
    step(12);
    check("R6 strobe held by request", rd_n, 0);
    dev_req_n = 1;
    step(2);
    check("R6 strobe before release seen", rd_n, 0);
    step(1);
    check("R6 strobe ends", rd_n, 1);
    check("R6 bus_req drops", bus_req, 0);
    check("R6 grant never low", c_gnt, 0);

    // R6 paced short request, wait 5
    wait_cfg = 5; clr();
    dev_req_n = 0; step(1); dev_req_n = 1;
    step(15);
    check("R6 short request strobe width", c_rd, 6);
    check("R6 grant never low short", c_gnt, 0);

    // R7 disabled channel and idle request line
    chan_en = 0; mode_cfg = 2'b00; clr();
    dev_req_n = 0; step(3); dev_req_n = 1;
    step(8);
    check("R7 disabled ignores request", c_breq, 0);
    chan_en = 1; clr();
    step(10);
    check("R7 request high no action", c_breq + c_gnt + c_rd + c_wr, 0);

    // R8 reserved mode
    mode_cfg = 2'b11; clr();
    dev_req_n = 0; step(6); dev_req_n = 1;
    step(6);
    check("R8 reserved ignored", c_breq + c_gnt + c_rd + c_wr, 0);

    // R9 configuration change mid-transfer
    mode_cfg = 2'b01; dir_cfg = 1; wait_cfg = 4; clr();
    dev_req_n = 0;
    k = 0;
    while (mem_sel_n && k < 20) begin step(1); k++; end
    mode_cfg = 2'b10; dir_cfg = 0;
    step(12);
    check("R9 direction kept", c_wr, 5);
    check("R9 no read strobe", c_rd, 0);
    check("R9 mode kept, grant held", dev_gnt_n, 0);
    dev_req_n = 1;
    step(5);
    check("R9 return to idle", bus_req, 0);

    finish_run();
  end
endmodule